// File: doc/BRIEF.md
# Saturating Integer ALU Lane

This block is one lane of a vector integer ALU. Each accepted operation reads an opcode, a clamp enable, two full-width sources, a half-width third source and a carry-in bit. It returns a full-width result and a flag bit. The operations are add, subtract and reverse subtract on three data types: half-width unsigned, full-width unsigned and full-width signed. The block also has full-width unsigned add, subtract and reverse subtract that produce a carry, in forms that ignore or consume a carry-in. A half-width multiply-add and a full-width multiply-low complete the set.

When clamp is low, every result wraps modulo the destination width. When clamp is high, a result that does not fit is replaced by the nearest limit of its destination type. Multiply-low is the exception: it always returns the low product bits. The flag always reports the unclamped condition, whatever the clamp setting.

The lane has one register stage. The result and its valid come out one clock after the operation is accepted. With the default parameter, the full width is 32 bits and the half width is 16 bits.

Top module: `clamp_alu_lane`

## Requirements
- R1: Opcodes: 0/1/2 = half unsigned add/sub/reverse-sub; 3/4/5 = full unsigned add/sub/reverse-sub; 6/7/8 = full signed add/sub/reverse-sub; 9/10/11 = full unsigned carry add/sub/reverse-sub without carry-in; 12/13/14 = the same with carry-in added (add) or borrow-in subtracted (sub); 15 = half multiply-add src0*src1+src2; 16 = full multiply-low. Codes 17 to 31 act as code 3. Sub computes src0-src1 and reverse-sub computes src1-src0.
- R2: With clamp low, every result wraps modulo its destination width (for example, half multiply-add 0xFFFF*2+0 gives 0xFFFE).
- R3: With clamp high, an unsigned add that exceeds the destination range returns all ones of that width (0xFFFF for half, 0xFFFFFFFF for full).
- R4: With clamp high, an unsigned subtract that goes below zero returns 0.
- R5: With clamp high, a signed add or subtract returns 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow.
- R6: Reverse subtracts clamp the reversed difference src1-src0.
- R7: Multiply-add computes at full precision and then limits once to the half-width maximum (with clamp, 0x8000*2+0x1000 gives 0xFFFF and 100*100+50 gives 10050).
- R8: For the carry ops, carry-in or borrow-in takes part in range detection. With clamp high, a carry out gives all ones and a borrow out gives 0 (0xFFFFFFFE+1+carry 1 gives 0xFFFFFFFF).
- R9: Multiply-low returns the low full-width product bits and never saturates, even with clamp high.
- R10: A result that fits its range is the same with clamp high or low (-100 + -200 signed gives 0xFFFFFED4).
- R11: Half-width operations read only the low half of src0 and src1 and return zero in the upper half of the result.
- R12: The flag output is the unclamped condition: the carry or borrow at the destination width for unsigned add and sub, signed overflow for signed ops, and nonzero discarded high bits for multiply-add and multiply-low. The carry-in has no effect outside codes 12 to 14.
- R13: The result, flag and out_valid appear one clock after in_valid. out_valid is low one clock after a cycle with in_valid low. Reset clears out_valid, result and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 5 | Operation select (see R1) |
| clamp_en | input | 1 | Saturate instead of wrap |
| src0 | input | DATA_W | First source |
| src1 | input | DATA_W | Second source |
| src2 | input | DATA_W/2 | Addend for the multiply-add |
| carry_in | input | 1 | Carry or borrow in for codes 12 to 14 |
| out_valid | output | 1 | Result valid |
| result | output | DATA_W | Operation result |
| carry_out | output | 1 | Unclamped carry, borrow or overflow flag |

## Verification
The bench builds two copies of the lane. The first uses the default 32-bit width and receives directed operands at the exact range edges named in the requirements. The second is built with a 4-bit full width and a 2-bit half width. At that size, every operand pair, both clamp states and both carry-in values can be applied to every opcode. For the multiply-add, every third operand is applied as well. This exhaustive sweep covers every carry, borrow and overflow boundary of each type against an arithmetic model in the bench.

// File: rtl/clamp_lane_pkg.sv
package clamp_lane_pkg;
  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_ADDH  = 5'd0,  OP_SUBH  = 5'd1,  OP_RSBH  = 5'd2,
    OP_ADDU  = 5'd3,  OP_SUBU  = 5'd4,  OP_RSBU  = 5'd5,
    OP_ADDS  = 5'd6,  OP_SUBS  = 5'd7,  OP_RSBS  = 5'd8,
    OP_ADDC  = 5'd9,  OP_SUBC  = 5'd10, OP_RSBC  = 5'd11,
    OP_ADDCI = 5'd12, OP_SUBCI = 5'd13, OP_RSBCI = 5'd14,
    OP_MADH  = 5'd15, OP_MULLO = 5'd16
  } lane_op_e;

  typedef enum logic [1:0] {SAT_NONE, SAT_HI, SAT_LO, SAT_SGN} sat_kind_e;

  typedef struct packed {
    logic      half;
    logic      sgn;
    logic      sub;
    logic      rev;
    logic      use_cin;
    logic      mad;
    logic      mul;
    sat_kind_e kind;
  } lane_ctl_t;

  // Groups of three share one layout: add, sub, reverse sub.
  function automatic lane_ctl_t decode_op(input logic [OPC_W-1:0] code);
    lane_ctl_t c;
    c      = '0;
    c.kind = SAT_HI;
    if (code < OP_MADH) begin
      c.half    = (code < OP_ADDU);
      c.sgn     = (code >= OP_ADDS) && (code < OP_ADDC);
      c.use_cin = (code >= OP_ADDCI);
      c.sub     = (code % 5'd3) != 5'd0;
      c.rev     = (code % 5'd3) == 5'd2;
      c.kind    = c.sgn ? SAT_SGN : (c.sub ? SAT_LO : SAT_HI);
    end else if (code == OP_MADH) begin
      c.half = 1'b1;
      c.mad  = 1'b1;
    end else if (code == OP_MULLO) begin
      c.mul  = 1'b1;
      c.kind = SAT_NONE;
    end
    return c;
  endfunction
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import clamp_lane_pkg::*;
(
  input  logic [OPC_W-1:0] op_code,
  output lane_ctl_t        ctl
);
  assign ctl = decode_op(op_code);
endmodule

// File: rtl/lane_addsub.sv
module lane_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              half,
  input  logic              sgn,
  input  logic              sub,
  input  logic              cin,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] wrap,
  output logic              flag,
  output logic              sign_hint
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W + 1;

  function automatic logic [EXT_W-1:0] narrow(input logic [DATA_W-1:0] v, input logic h);
    return h ? EXT_W'(v[HALF_W-1:0]) : EXT_W'(v);
  endfunction

  function automatic logic [EXT_W-1:0] combine(input logic [EXT_W-1:0] a, input logic [EXT_W-1:0] b,
                                               input logic s, input logic c);
    return s ? (a - b - EXT_W'(c)) : (a + b + EXT_W'(c));
  endfunction

  function automatic logic sign_ovf(input logic am, input logic bm, input logic rm, input logic s);
    return s ? ((am != bm) && (rm != am)) : ((am == bm) && (rm != am));
  endfunction

  logic [EXT_W-1:0] ext_a, ext_b, total;
  logic             carry_u, ovf_s;

  assign ext_a     = narrow(opa, half);
  assign ext_b     = narrow(opb, half);
  assign total     = combine(ext_a, ext_b, sub, cin);
  assign carry_u   = half ? total[HALF_W] : total[DATA_W];
  assign ovf_s     = sign_ovf(opa[DATA_W-1], opb[DATA_W-1], total[DATA_W-1], sub);
  assign flag      = sgn ? ovf_s : carry_u;
  assign wrap      = half ? DATA_W'(total[HALF_W-1:0]) : total[DATA_W-1:0];
  assign sign_hint = opa[DATA_W-1];
endmodule

// File: rtl/lane_mul.sv
module lane_mul #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  input  logic [DATA_W/2-1:0] addend,
  output logic [DATA_W-1:0]   mad_wrap,
  output logic                mad_flag,
  output logic [DATA_W-1:0]   lo_wrap,
  output logic                lo_flag
);
  localparam int HALF_W = DATA_W / 2;
  localparam int MAD_W  = 2 * HALF_W + 1;
  localparam int PRD_W  = 2 * DATA_W;

  function automatic logic [MAD_W-1:0] mad_full(input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b,
                                                input logic [HALF_W-1:0] c);
    return MAD_W'(a) * MAD_W'(b) + MAD_W'(c);
  endfunction

  function automatic logic [PRD_W-1:0] mul_full(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return PRD_W'(a) * PRD_W'(b);
  endfunction

  logic [MAD_W-1:0] mad_v;
  logic [PRD_W-1:0] prod_v;

  assign mad_v    = mad_full(opa[HALF_W-1:0], opb[HALF_W-1:0], addend);
  assign mad_flag = |mad_v[MAD_W-1:HALF_W];
  assign mad_wrap = DATA_W'(mad_v[HALF_W-1:0]);

  assign prod_v   = mul_full(opa, opb);
  assign lo_flag  = |prod_v[PRD_W-1:DATA_W];
  assign lo_wrap  = prod_v[DATA_W-1:0];
endmodule

// File: rtl/lane_clamp.sv
module lane_clamp
  import clamp_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clamp_en,
  input  sat_kind_e         kind,
  input  logic              half,
  input  logic              sign_hint,
  input  logic              flag,
  input  logic [DATA_W-1:0] wrap,
  output logic [DATA_W-1:0] res,
  output logic              sat_apply
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] limit;

  always_comb begin
    case (kind)
      SAT_HI:  limit = half ? DATA_W'({HALF_W{1'b1}}) : {DATA_W{1'b1}};
      SAT_SGN: limit = sign_hint ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
      default: limit = '0;
    endcase
  end

  assign sat_apply = clamp_en && flag && (kind != SAT_NONE);
  assign res       = sat_apply ? limit : wrap;
endmodule

// File: rtl/clamp_alu_lane.sv
module clamp_alu_lane
  import clamp_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [4:0]          op_code,
  input  logic                clamp_en,
  input  logic [DATA_W-1:0]   src0,
  input  logic [DATA_W-1:0]   src1,
  input  logic [DATA_W/2-1:0] src2,
  input  logic                carry_in,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                carry_out
);
  lane_ctl_t         ctl;
  logic [DATA_W-1:0] opnd_x, opnd_y;
  logic              cin_eff;
  logic [DATA_W-1:0] add_wrap, mad_wrap, lo_wrap, sel_wrap, sat_value;
  logic              add_flag, mad_flag, lo_flag, sel_flag, sign_hint, sat_apply;

  lane_decode u_dec (.op_code(op_code), .ctl(ctl));

  // Reverse forms swap the operands before the shared adder.
  assign opnd_x  = ctl.rev ? src1 : src0;
  assign opnd_y  = ctl.rev ? src0 : src1;
  assign cin_eff = ctl.use_cin & carry_in;

  lane_addsub #(.DATA_W(DATA_W)) u_add (
    .half(ctl.half), .sgn(ctl.sgn), .sub(ctl.sub), .cin(cin_eff),
    .opa(opnd_x), .opb(opnd_y), .wrap(add_wrap), .flag(add_flag), .sign_hint(sign_hint)
  );

  lane_mul #(.DATA_W(DATA_W)) u_mul (
    .opa(src0), .opb(src1), .addend(src2),
    .mad_wrap(mad_wrap), .mad_flag(mad_flag), .lo_wrap(lo_wrap), .lo_flag(lo_flag)
  );

  assign sel_wrap = ctl.mul ? lo_wrap  : (ctl.mad ? mad_wrap : add_wrap);
  assign sel_flag = ctl.mul ? lo_flag  : (ctl.mad ? mad_flag : add_flag);

  lane_clamp #(.DATA_W(DATA_W)) u_clamp (
    .clamp_en(clamp_en), .kind(ctl.kind), .half(ctl.half), .sign_hint(sign_hint),
    .flag(sel_flag), .wrap(sel_wrap), .res(sat_value), .sat_apply(sat_apply)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sat_value;
        carry_out <= sel_flag;
      end
    end
  end
endmodule

// File: rtl/clamp_alu_lane_chk.sv
module clamp_alu_lane_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [4:0]        op_code,
  input logic              clamp_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              sel_flag,
  input logic              sat_apply
);
  localparam int HALF_W = DATA_W / 2;

  p_valid_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_no_clamp_no_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |-> !sat_apply);
  p_mullo_no_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 5'd16) |-> !sat_apply);
  p_half_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_code < 5'd3 || op_code == 5'd15)) |=> (result[DATA_W-1:HALF_W] == '0));
  p_add_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clamp_en && (op_code == 5'd3 || op_code == 5'd9 || op_code == 5'd12))
    |=> (!carry_out || (&result)));
  p_sub_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clamp_en && (op_code inside {5'd1, 5'd2, 5'd4, 5'd5, 5'd10, 5'd11, 5'd13, 5'd14}))
    |=> (!carry_out || (result == '0)));
  p_flag_carried_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (carry_out == $past(sel_flag)));
endmodule

bind clamp_alu_lane clamp_alu_lane_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code), .clamp_en(clamp_en),
  .out_valid(out_valid), .result(result), .carry_out(carry_out),
  .sel_flag(sel_flag), .sat_apply(sat_apply)
);

// File: tb/test_clamp_alu_lane.sv
`timescale 1ns/1ps
module test_clamp_alu_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // 32-bit copy for directed edges
  logic        b_v = 0, b_cl = 0, b_ci = 0;
  logic [4:0]  b_op = 0;
  logic [31:0] b_s0 = 0, b_s1 = 0;
  logic [15:0] b_s2 = 0;
  logic        b_ov, b_co;
  logic [31:0] b_res;

  // 4-bit copy for exhaustive sweeps
  logic        s_v = 0, s_cl = 0, s_ci = 0;
  logic [4:0]  s_op = 0;
  logic [3:0]  s_s0 = 0, s_s1 = 0;
  logic [1:0]  s_s2 = 0;
  logic        s_ov, s_co;
  logic [3:0]  s_res;

  clamp_alu_lane i_clamp_alu_lane (
    .clk(clk), .rst_n(rst_n), .in_valid(b_v), .op_code(b_op), .clamp_en(b_cl),
    .src0(b_s0), .src1(b_s1), .src2(b_s2), .carry_in(b_ci),
    .out_valid(b_ov), .result(b_res), .carry_out(b_co)
  );

  clamp_alu_lane #(.DATA_W(4)) i_clamp_alu_lane_w4 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_v), .op_code(s_op), .clamp_en(s_cl),
    .src0(s_s0), .src1(s_s1), .src2(s_s2), .carry_in(s_ci),
    .out_valid(s_ov), .result(s_res), .carry_out(s_co)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference arithmetic: range comparisons on wide integers.
  function automatic logic [32:0] model(input int w, input int op, input bit cl,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input bit ci);
    int h = w / 2;
    int k;
    logic [63:0] mw, mh, m, xa, xb, tmp, v, r, cv;
    longint sa, sb, sv, smax, smin;
    bit fl;
    mw = (64'd1 << w) - 64'd1;
    mh = (64'd1 << h) - 64'd1;
    fl = 0;
    r  = 0;
    k  = (op > 16) ? 3 : op;
    if (k == 16) begin
      v  = ({32'd0, a} & mw) * ({32'd0, b} & mw);
      fl = (v >> w) != 64'd0;
      r  = v & mw;
    end else if (k == 15) begin
      v  = ({32'd0, a} & mh) * ({32'd0, b} & mh) + ({32'd0, c} & mh);
      fl = v > mh;
      r  = (cl && fl) ? mh : (v & mh);
    end else if (k >= 6 && k <= 8) begin
      xa = {32'd0, a} & mw;
      xb = {32'd0, b} & mw;
      if (k == 8) begin tmp = xa; xa = xb; xb = tmp; end
      sa = xa[w-1] ? longint'(xa) - longint'(64'd1 << w) : longint'(xa);
      sb = xb[w-1] ? longint'(xb) - longint'(64'd1 << w) : longint'(xb);
      sv = (k == 6) ? sa + sb : sa - sb;
      smax = (longint'(1) << (w - 1)) - 1;
      smin = -smax - 1;
      fl = (sv > smax) || (sv < smin);
      if (cl && fl) sv = (sv > smax) ? smax : smin;
      r = 64'(sv) & mw;
    end else begin
      m  = (k < 3) ? mh : mw;
      xa = {32'd0, a} & m;
      xb = {32'd0, b} & m;
      if (k % 3 == 2) begin tmp = xa; xa = xb; xb = tmp; end
      cv = (k >= 12) ? 64'(ci) : 64'd0;
      if (k % 3 == 0) begin
        v  = xa + xb + cv;
        fl = v > m;
        r  = (cl && fl) ? m : (v & m);
      end else begin
        fl = xa < (xb + cv);
        v  = xa - xb - cv;
        r  = (cl && fl) ? 64'd0 : (v & m);
      end
    end
    return {fl, r[31:0]};
  endfunction

  function automatic string tag_of(input int op, input bit cl);
    if (op == 16) return "R9";
    if (op == 15) return "R7";
    if (op >= 12) return "R8";
    if (op >= 6 && op <= 8) return "R5";
    if (op % 3 == 2) return "R6";
    if (!cl) return "R2";
    if (op % 3 == 0) return "R3";
    return "R4";
  endfunction

  task automatic run_big(input int op, input bit cl, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] c, input bit ci, input logic [31:0] er,
                         input bit ef, input string req);
    b_v = 1; b_op = 5'(op); b_cl = cl; b_s0 = a; b_s1 = b; b_s2 = c; b_ci = ci;
    @(negedge clk);
    check("R13 valid", {31'd0, b_ov}, 32'd1);
    check(req, b_res, er);
    check("R12 flag", {31'd0, b_co}, {31'd0, ef});
  endtask

  task automatic run_small(input int op, input bit cl, input int a, input int b, input int c, input bit ci);
    logic [32:0] e;
    s_v = 1; s_op = 5'(op); s_cl = cl; s_s0 = 4'(a); s_s1 = 4'(b); s_s2 = 2'(c); s_ci = ci;
    e = model(4, op, cl, 32'(a), 32'(b), 32'(c), ci);
    @(negedge clk);
    check("R13 valid", {31'd0, s_ov}, 32'd1);
    check(tag_of(op, cl), {28'd0, s_res}, e[31:0]);
    check("R12 flag", {31'd0, s_co}, {31'd0, e[32]});
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset valid", {31'd0, b_ov}, 32'd0);
    check("R13 reset result", b_res, 32'd0);
    check("R13 reset flag", {31'd0, b_co}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    run_big(15, 0, 32'hFFFF, 32'd2, 16'd0, 0, 32'h0000FFFE, 1, "R2 mad wrap");
    run_big(3, 1, 32'hFFFFFFFF, 32'd1, 16'd0, 0, 32'hFFFFFFFF, 1, "R3 full add");
    run_big(0, 1, 32'h0000FFFF, 32'd1, 16'd0, 0, 32'h0000FFFF, 1, "R3 half add");
    run_big(4, 1, 32'd0, 32'd1, 16'd0, 0, 32'd0, 1, "R4 full sub");
    run_big(1, 1, 32'd0, 32'd1, 16'd0, 0, 32'd0, 1, "R4 half sub");
    run_big(7, 1, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'd0, 0, 32'h7FFFFFFF, 1, "R5 pos");
    run_big(6, 1, 32'h80000000, 32'hFFFFFFFF, 16'd0, 0, 32'h80000000, 1, "R5 neg");
    run_big(11, 1, 32'd1, 32'd0, 16'd0, 0, 32'd0, 1, "R6 reverse");
    run_big(5, 1, 32'd50, 32'd300, 16'd0, 0, 32'd250, 0, "R6 reverse fits");
    run_big(15, 1, 32'h8000, 32'd2, 16'h1000, 0, 32'h0000FFFF, 1, "R7 mad sat");
    run_big(15, 1, 32'd100, 32'd100, 16'd50, 0, 32'd10050, 0, "R7 mad fits");
    run_big(12, 1, 32'hFFFFFFFE, 32'd1, 16'd0, 1, 32'hFFFFFFFF, 1, "R8 carry in");
    run_big(12, 1, 32'hFFFFFFFE, 32'd1, 16'd0, 0, 32'hFFFFFFFF, 0, "R8 no carry in");
    run_big(13, 1, 32'd5, 32'd5, 16'd0, 1, 32'd0, 1, "R8 borrow in");
    run_big(16, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'd0, 0, 32'd1, 1, "R9 mullo");
    run_big(6, 1, 32'hFFFFFF9C, 32'hFFFFFF38, 16'd0, 0, 32'hFFFFFED4, 0, "R10 clamp on");
    run_big(6, 0, 32'hFFFFFF9C, 32'hFFFFFF38, 16'd0, 0, 32'hFFFFFED4, 0, "R10 clamp off");
    run_big(0, 0, 32'hABCD0005, 32'h12340003, 16'd0, 0, 32'd8, 0, "R11 half upper");
    run_big(3, 0, 32'd7, 32'd9, 16'd0, 1, 32'd16, 0, "R12 cin ignored");
    run_big(20, 0, 32'd5, 32'd7, 16'd0, 0, 32'd12, 0, "R1 spare code");
    b_v = 0;
    @(negedge clk);
    check("R13 idle", {31'd0, b_ov}, 32'd0);

    for (int op = 0; op < 17; op++)
      for (int cl = 0; cl < 2; cl++)
        for (int ci = 0; ci < 2; ci++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              for (int c = 0; c < ((op == 15) ? 4 : 1); c++)
                run_small(op, cl[0], a, b, (op == 15) ? c : (a ^ b), ci[0]);
    s_v = 0;
    @(negedge clk);
    check("R13 idle small", {31'd0, s_ov}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule